// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home node for a small group of cache blocks shared by several private caches. For every block it holds a presence vector with one bit per cache, an exclusive flag and the block's data word. Caches send it read, read-for-ownership and upgrade requests. It answers each one with shared data, exclusive data, an ownership grant without data, or a refusal. Where other copies must be removed or demoted first, it sends one point-to-point message to each affected cache. It then counts their replies before it completes the original request.

While an entry waits for replies it is marked busy. Any further request to that entry is refused at once, and the requester is expected to try again later. Entries that are not busy keep serving requests, so unrelated blocks are not held up by a slow invalidation. All message channels use valid/ready handshakes, except the reply channel from the caches, which is always accepted.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is idle with no presence bits set, its data word equals DATA_INIT plus the block index, no response or invalidation is offered, and a request is accepted.
- R2: A read (req_type 0) to a block that no other cache holds is answered in the same cycle with exclusive data (rsp_type 1), and the requester becomes the only holder with the exclusive flag set.
- R3: A read to a block held in shared form by other caches is answered in the same cycle with shared data (rsp_type 0), the requester's presence bit is added and the exclusive flag is cleared.
- R4: A read to a block held exclusively by another cache first sends that owner a downgrade (inv_down 1); after the owner's reply (its data replaces the stored word when ack_dirty is 1) the requester receives shared data (rsp_type 0) and both caches remain holders.
- R5: A read-for-ownership (req_type 1) to a block with other holders sends an invalidation (inv_down 0) to each other holder exactly once and never to the requester, then replies with exclusive data (rsp_type 1) and leaves the requester as the only, exclusive holder.
- R6: When the invalidated holder was an exclusive owner and replies with ack_dirty 1, the exclusive data sent to the requester is the word carried by that reply.
- R7: An upgrade (req_type 2) from a cache whose presence bit is set invalidates the other holders and then answers with an ownership grant (rsp_type 2) whose rsp_data is zero; with no other holders the grant comes in the same cycle.
- R8: A request to an entry that is busy is answered in the same cycle with a refusal (rsp_type 3, rsp_data zero), and the entry's holders and exclusive flag stay as they were.
- R9: A busy entry gives no completion response until every invalidation has been sent and as many replies as invalidations have arrived.
- R10: Requests to two different entries that are not busy are accepted on consecutive cycles.
- R11: For one entry, the invalidations leave in ascending cache index order. Across entries, the lowest busy entry index with messages still to send goes first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_type | input | 2 | 0 read, 1 read-for-ownership, 2 upgrade |
| req_src | input | $clog2(NUM_CACHES) | Requesting cache |
| req_blk | input | $clog2(NUM_BLOCKS) | Target entry |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_type | output | 2 | 0 shared data, 1 exclusive data, 2 grant, 3 refusal |
| rsp_dst | output | $clog2(NUM_CACHES) | Cache receiving the response |
| rsp_blk | output | $clog2(NUM_BLOCKS) | Entry the response concerns |
| rsp_data | output | DATA_W | Block data, zero for grant and refusal |
| inv_valid | output | 1 | Invalidation or downgrade offered |
| inv_ready | input | 1 | Invalidation taken |
| inv_down | output | 1 | 1 downgrade to shared, 0 invalidate |
| inv_dst | output | $clog2(NUM_CACHES) | Cache addressed |
| inv_blk | output | $clog2(NUM_BLOCKS) | Entry addressed |
| ack_valid | input | 1 | Reply from a cache to an earlier invalidation |
| ack_blk | input | $clog2(NUM_BLOCKS) | Entry the reply concerns |
| ack_dirty | input | 1 | Reply carries updated data |
| ack_data | input | DATA_W | Updated data word |

## Verification
The assertions assume that a cache replies only to an entry that is busy, and only after that entry has sent it a message. They also assume that no entry receives more replies than it sent messages, that req_blk names an existing entry and that req_type is never 3. The stimulus keeps to this: it sends a reply only after it has seen the matching invalidation leave the block, and one reply per invalidation. Every request it makes uses a valid type and block index. It holds rsp_ready and inv_ready high, so each offered message is taken in the cycle it appears.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;
   localparam logic [1:0] RQ_READ = 2'd0;
   localparam logic [1:0] RQ_RDEX = 2'd1;
   localparam logic [1:0] RQ_UPGR = 2'd2;

   localparam logic [1:0] RS_SHR  = 2'd0;
   localparam logic [1:0] RS_EXC  = 2'd1;
   localparam logic [1:0] RS_GNT  = 2'd2;
   localparam logic [1:0] RS_NACK = 2'd3;
endpackage

// File: rtl/dir_req_plan.sv
module dir_req_plan
   import dir_home_pkg::*;
#(
   parameter int NUM_CACHES = 4,
   localparam int SW = $clog2(NUM_CACHES),
   localparam int CW = $clog2(NUM_CACHES + 1)
) (
   input  logic [NUM_CACHES-1:0] pres,
   input  logic                  excl,
   input  logic                  busy,
   input  logic [1:0]            rtype,
   input  logic [SW-1:0]         src,
   output logic                  imm,
   output logic [1:0]            imm_type,
   output logic                  need_inv,
   output logic                  down,
   output logic [NUM_CACHES-1:0] mask,
   output logic [CW-1:0]         cnt,
   output logic [NUM_CACHES-1:0] nxt_pres,
   output logic                  nxt_excl,
   output logic [1:0]            fin_type
);
   logic [NUM_CACHES-1:0] src_bit;
   logic [NUM_CACHES-1:0] others;

   always_comb begin
      src_bit      = '0;
      src_bit[src] = 1'b1;
      others       = pres & ~src_bit;
      imm          = 1'b0;
      imm_type     = RS_SHR;
      need_inv     = 1'b0;
      down         = 1'b0;
      mask         = '0;
      nxt_pres     = pres;
      nxt_excl     = excl;
      fin_type     = RS_EXC;
      if (busy) begin
         imm      = 1'b1;
         imm_type = RS_NACK;
      end else if (rtype == RQ_RDEX || rtype == RQ_UPGR) begin
         fin_type = (rtype == RQ_UPGR && pres[src]) ? RS_GNT : RS_EXC;
         nxt_pres = src_bit;
         nxt_excl = 1'b1;
         if (others == '0) begin
            imm      = 1'b1;
            imm_type = fin_type;
         end else begin
            need_inv = 1'b1;
            mask     = others;
         end
      end else if (excl && others != '0) begin
         need_inv = 1'b1;
         down     = 1'b1;
         mask     = others;
         fin_type = RS_SHR;
         nxt_pres = pres | src_bit;
         nxt_excl = 1'b0;
      end else if (others == '0) begin
         imm      = 1'b1;
         imm_type = RS_EXC;
         nxt_pres = src_bit;
         nxt_excl = 1'b1;
      end else begin
         imm      = 1'b1;
         imm_type = RS_SHR;
         nxt_pres = pres | src_bit;
         nxt_excl = 1'b0;
      end
   end

   always_comb begin
      cnt = '0;
      for (int i = 0; i < NUM_CACHES; i++) cnt = cnt + CW'(mask[i]);
   end
endmodule

// File: rtl/dir_entry.sv
module dir_entry
   import dir_home_pkg::*;
#(
   parameter int NUM_CACHES = 4,
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] INIT_DATA = '0,
   localparam int SW = $clog2(NUM_CACHES),
   localparam int CW = $clog2(NUM_CACHES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_imm,
   input  logic                  load_busy,
   input  logic [NUM_CACHES-1:0] nxt_pres,
   input  logic                  nxt_excl,
   input  logic [NUM_CACHES-1:0] mask,
   input  logic [CW-1:0]         cnt,
   input  logic                  down,
   input  logic [1:0]            fin,
   input  logic [SW-1:0]         src,
   input  logic                  ack_hit,
   input  logic                  ack_dirty,
   input  logic [DATA_W-1:0]     ack_data,
   input  logic [NUM_CACHES-1:0] clr_bits,
   input  logic                  cmp_take,
   output logic [NUM_CACHES-1:0] pres,
   output logic                  excl,
   output logic                  busy,
   output logic [NUM_CACHES-1:0] send,
   output logic                  down_q,
   output logic                  done,
   output logic [1:0]            fin_q,
   output logic [SW-1:0]         src_q,
   output logic [DATA_W-1:0]     data
);
   logic [CW-1:0]         cnt_q;
   logic [NUM_CACHES-1:0] pend_pres;
   logic                  pend_excl;

   assign done = busy && (cnt_q == '0) && (send == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pres      <= '0;
         excl      <= 1'b0;
         busy      <= 1'b0;
         send      <= '0;
         cnt_q     <= '0;
         down_q    <= 1'b0;
         fin_q     <= RS_EXC;
         src_q     <= '0;
         pend_pres <= '0;
         pend_excl <= 1'b0;
         data      <= INIT_DATA;
      end else begin
         if (load_imm) begin
            pres <= nxt_pres;
            excl <= nxt_excl;
         end
         if (load_busy) begin
            busy      <= 1'b1;
            send      <= mask;
            cnt_q     <= cnt;
            down_q    <= down;
            fin_q     <= fin;
            src_q     <= src;
            pend_pres <= nxt_pres;
            pend_excl <= nxt_excl;
         end else begin
            send <= send & ~clr_bits;
            if (ack_hit && busy) begin
               cnt_q <= cnt_q - CW'(1);
               if (ack_dirty) data <= ack_data;
            end
         end
         if (cmp_take) begin
            busy <= 1'b0;
            pres <= pend_pres;
            excl <= pend_excl;
         end
      end
   end
endmodule

// File: rtl/dir_inv_pick.sv
module dir_inv_pick #(
   parameter int NUM_BLOCKS = 4,
   parameter int NUM_CACHES = 4,
   localparam int BW = $clog2(NUM_BLOCKS),
   localparam int SW = $clog2(NUM_CACHES)
) (
   input  logic [NUM_BLOCKS-1:0][NUM_CACHES-1:0] send,
   output logic                                  valid,
   output logic [BW-1:0]                         blk,
   output logic [SW-1:0]                         dst
);
   always_comb begin
      valid = 1'b0;
      blk   = '0;
      dst   = '0;
      for (int b = NUM_BLOCKS - 1; b >= 0; b--) begin
         if (send[b] != '0) begin
            valid = 1'b1;
            blk   = BW'(b);
         end
      end
      for (int c = NUM_CACHES - 1; c >= 0; c--) begin
         if (send[blk][c]) dst = SW'(c);
      end
   end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_home_pkg::*;
#(
   parameter int NUM_CACHES = 4,
   parameter int NUM_BLOCKS = 4,
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] DATA_INIT = 16'hD000,
   localparam int SW = $clog2(NUM_CACHES),
   localparam int BW = $clog2(NUM_BLOCKS),
   localparam int CW = $clog2(NUM_CACHES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_type,
   input  logic [SW-1:0]     req_src,
   input  logic [BW-1:0]     req_blk,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [1:0]        rsp_type,
   output logic [SW-1:0]     rsp_dst,
   output logic [BW-1:0]     rsp_blk,
   output logic [DATA_W-1:0] rsp_data,
   output logic              inv_valid,
   input  logic              inv_ready,
   output logic              inv_down,
   output logic [SW-1:0]     inv_dst,
   output logic [BW-1:0]     inv_blk,
   input  logic              ack_valid,
   input  logic [BW-1:0]     ack_blk,
   input  logic              ack_dirty,
   input  logic [DATA_W-1:0] ack_data
);
   if (NUM_CACHES < 2) begin : g_bad_caches
      $error("dir_home_ctrl: NUM_CACHES must be at least 2");
   end
   if (NUM_BLOCKS < 2 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_bad_blocks
      $error("dir_home_ctrl: NUM_BLOCKS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dir_home_ctrl: DATA_W must be positive");
   end

   logic [NUM_BLOCKS-1:0][NUM_CACHES-1:0] ent_pres, ent_send;
   logic [NUM_BLOCKS-1:0]                 ent_excl, ent_busy, ent_down, ent_done;
   logic [NUM_BLOCKS-1:0][1:0]            ent_fin;
   logic [NUM_BLOCKS-1:0][SW-1:0]         ent_src;
   logic [NUM_BLOCKS-1:0][DATA_W-1:0]     ent_data;

   logic                  pl_imm, pl_need, pl_down, pl_nxt_excl;
   logic [1:0]            pl_imm_type, pl_fin;
   logic [NUM_CACHES-1:0] pl_mask, pl_nxt_pres, clr_onehot;
   logic [CW-1:0]         pl_cnt;
   logic                  acc, cmp_any, pick_valid;
   logic [BW-1:0]         cmp_blk, pick_blk;
   logic [SW-1:0]         pick_dst;

   dir_req_plan #(.NUM_CACHES(NUM_CACHES)) u_plan (
      .pres(ent_pres[req_blk]), .excl(ent_excl[req_blk]), .busy(ent_busy[req_blk]),
      .rtype(req_type), .src(req_src), .imm(pl_imm), .imm_type(pl_imm_type),
      .need_inv(pl_need), .down(pl_down), .mask(pl_mask), .cnt(pl_cnt),
      .nxt_pres(pl_nxt_pres), .nxt_excl(pl_nxt_excl), .fin_type(pl_fin)
   );

   dir_inv_pick #(.NUM_BLOCKS(NUM_BLOCKS), .NUM_CACHES(NUM_CACHES)) u_pick (
      .send(ent_send), .valid(pick_valid), .blk(pick_blk), .dst(pick_dst)
   );

   always_comb begin
      cmp_any = 1'b0;
      cmp_blk = '0;
      for (int b = NUM_BLOCKS - 1; b >= 0; b--) begin
         if (ent_done[b]) begin
            cmp_any = 1'b1;
            cmp_blk = BW'(b);
         end
      end
   end

   assign req_ready = !cmp_any && (pl_imm ? rsp_ready : 1'b1);
   assign acc       = req_valid && req_ready;
   assign rsp_valid = cmp_any || (req_valid && pl_imm);

   always_comb begin
      if (cmp_any) begin
         rsp_type = ent_fin[cmp_blk];
         rsp_dst  = ent_src[cmp_blk];
         rsp_blk  = cmp_blk;
         rsp_data = (ent_fin[cmp_blk] == RS_GNT) ? '0 : ent_data[cmp_blk];
      end else begin
         rsp_type = pl_imm_type;
         rsp_dst  = req_src;
         rsp_blk  = req_blk;
         rsp_data = (pl_imm_type == RS_SHR || pl_imm_type == RS_EXC) ? ent_data[req_blk] : '0;
      end
   end

   assign inv_valid = pick_valid;
   assign inv_blk   = pick_blk;
   assign inv_dst   = pick_dst;
   assign inv_down  = ent_down[pick_blk];

   always_comb begin
      clr_onehot           = '0;
      clr_onehot[pick_dst] = inv_valid && inv_ready;
   end

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_ent
      logic sel;
      assign sel = (req_blk == BW'(b));
      dir_entry #(
         .NUM_CACHES(NUM_CACHES), .DATA_W(DATA_W),
         .INIT_DATA(DATA_W'(DATA_INIT + DATA_W'(b)))
      ) u_ent (
         .clk(clk), .rst_n(rst_n),
         .load_imm(acc && sel && pl_imm && !ent_busy[b]),
         .load_busy(acc && sel && pl_need),
         .nxt_pres(pl_nxt_pres), .nxt_excl(pl_nxt_excl), .mask(pl_mask),
         .cnt(pl_cnt), .down(pl_down), .fin(pl_fin), .src(req_src),
         .ack_hit(ack_valid && ack_blk == BW'(b)), .ack_dirty(ack_dirty),
         .ack_data(ack_data),
         .clr_bits((pick_blk == BW'(b)) ? clr_onehot : '0),
         .cmp_take(cmp_any && cmp_blk == BW'(b) && rsp_ready),
         .pres(ent_pres[b]), .excl(ent_excl[b]), .busy(ent_busy[b]),
         .send(ent_send[b]), .down_q(ent_down[b]), .done(ent_done[b]),
         .fin_q(ent_fin[b]), .src_q(ent_src[b]), .data(ent_data[b])
      );
   end
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
   parameter int NUM_CACHES = 4,
   parameter int NUM_BLOCKS = 4,
   localparam int SW = $clog2(NUM_CACHES),
   localparam int BW = $clog2(NUM_BLOCKS)
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  req_valid,
   input logic                                  req_ready,
   input logic [BW-1:0]                         req_blk,
   input logic                                  rsp_valid,
   input logic                                  rsp_ready,
   input logic [1:0]                            rsp_type,
   input logic [SW-1:0]                         rsp_dst,
   input logic [BW-1:0]                         rsp_blk,
   input logic                                  inv_valid,
   input logic [SW-1:0]                         inv_dst,
   input logic [BW-1:0]                         inv_blk,
   input logic [NUM_BLOCKS-1:0]                 ent_busy,
   input logic [NUM_BLOCKS-1:0]                 ent_excl,
   input logic [NUM_BLOCKS-1:0][NUM_CACHES-1:0] ent_pres,
   input logic [NUM_BLOCKS-1:0][SW-1:0]         ent_src
);
   // R8
   nack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_type == 2'd3 |-> ent_busy[rsp_blk]);

   // R8
   nack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && ent_busy[req_blk] |=> $stable(ent_pres) && $stable(ent_excl));

   // R9
   inv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> ent_busy[inv_blk]);

   // R5
   inv_not_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> inv_dst != ent_src[inv_blk]);

   // R2
   exc_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_ready && rsp_type == 2'd1 |=>
         ent_excl[$past(rsp_blk)] && ent_pres[$past(rsp_blk)][$past(rsp_dst)]
         && $countones(ent_pres[$past(rsp_blk)]) == 1);

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_ex
      // R5
      excl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ent_excl[b] |-> $countones(ent_pres[b]) == 1);
   end
endmodule

bind dir_home_ctrl dir_home_chk #(.NUM_CACHES(NUM_CACHES), .NUM_BLOCKS(NUM_BLOCKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_blk(req_blk), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_type(rsp_type), .rsp_dst(rsp_dst), .rsp_blk(rsp_blk),
   .inv_valid(inv_valid), .inv_dst(inv_dst), .inv_blk(inv_blk),
   .ent_busy(ent_busy), .ent_excl(ent_excl), .ent_pres(ent_pres), .ent_src(ent_src)
);

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ready;
   logic [1:0]  req_type = '0;
   logic [1:0]  req_src = '0, req_blk = '0;
   logic        rsp_valid, rsp_ready = 1'b1;
   logic [1:0]  rsp_type, rsp_dst, rsp_blk;
   logic [15:0] rsp_data;
   logic        inv_valid, inv_ready = 1'b1, inv_down;
   logic [1:0]  inv_dst, inv_blk;
   logic        ack_valid = 1'b0, ack_dirty = 1'b0;
   logic [1:0]  ack_blk = '0;
   logic [15:0] ack_data = '0;

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;

   typedef struct {
      logic [1:0]  t;
      logic [1:0]  dst;
      logic [1:0]  blk;
      logic [15:0] data;
      string       tag;
   } msg_t;
   msg_t rsp_q[$];
   msg_t inv_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dir_home_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_type(req_type), .req_src(req_src), .req_blk(req_blk),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type),
      .rsp_dst(rsp_dst), .rsp_blk(rsp_blk), .rsp_data(rsp_data),
      .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_down(inv_down),
      .inv_dst(inv_dst), .inv_blk(inv_blk), .ack_valid(ack_valid),
      .ack_blk(ack_blk), .ack_dirty(ack_dirty), .ack_data(ack_data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected items as the design emits them
   always @(negedge clk) begin
      #2;
      if (rst_n && !finished) begin
         if (rsp_valid && rsp_ready) begin
            if (rsp_q.size() == 0) begin
               chk(0, "unexpected response", {rsp_type, rsp_dst, rsp_blk}, 0);
            end else begin
               msg_t e;
               e = rsp_q.pop_front();
               chk(rsp_type == e.t && rsp_dst == e.dst && rsp_blk == e.blk && rsp_data == e.data,
                   e.tag, {rsp_type, 2'b0, rsp_dst, 2'b0, rsp_blk, rsp_data},
                   {e.t, 2'b0, e.dst, 2'b0, e.blk, e.data});
            end
         end
         if (inv_valid && inv_ready) begin
            if (inv_q.size() == 0) begin
               chk(0, "unexpected invalidation", {inv_down, inv_dst, inv_blk}, 0);
            end else begin
               msg_t e;
               e = inv_q.pop_front();
               chk(inv_down == e.t[0] && inv_dst == e.dst && inv_blk == e.blk,
                   e.tag, {inv_down, inv_dst, inv_blk}, {e.t[0], e.dst, e.blk});
            end
         end
      end
   end

   task automatic exp_rsp(input logic [1:0] t, input logic [1:0] d, input logic [1:0] b,
                          input logic [15:0] data, input string tag);
      msg_t m;
      m.t = t; m.dst = d; m.blk = b; m.data = data; m.tag = tag;
      rsp_q.push_back(m);
   endtask

   task automatic exp_inv(input logic down, input logic [1:0] d, input logic [1:0] b,
                          input string tag);
      msg_t m;
      m.t = {1'b0, down}; m.dst = d; m.blk = b; m.data = '0; m.tag = tag;
      inv_q.push_back(m);
   endtask

   int acc_cyc;
   task automatic send_req(input logic [1:0] t, input logic [1:0] s, input logic [1:0] b);
      @(negedge clk);
      req_valid = 1'b1; req_type = t; req_src = s; req_blk = b;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      acc_cyc = cyc;
      #1 req_valid = 1'b0;
   endtask

   task automatic send_ack(input logic [1:0] b, input logic dirty, input logic [15:0] d);
      @(negedge clk);
      ack_valid = 1'b1; ack_blk = b; ack_dirty = dirty; ack_data = d;
      @(posedge clk);
      #1 ack_valid = 1'b0;
   endtask

   task automatic wait_inv_empty();
      while (inv_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_idle();
      while (rsp_q.size() != 0 || inv_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(rsp_valid == 0, "R1 no response after reset", rsp_valid, 0);
      chk(inv_valid == 0, "R1 no invalidation after reset", inv_valid, 0);
      chk(req_ready == 1, "R1 ready after reset", req_ready, 1);

      // R2 / R1: fresh block, reset data
      exp_rsp(2'd1, 2'd0, 2'd0, 16'hD000, "R2 read fresh blk0 exclusive");
      send_req(2'd0, 2'd0, 2'd0);
      wait_idle();
      exp_rsp(2'd1, 2'd0, 2'd1, 16'hD001, "R1 R2 read fresh blk1 reset data");
      send_req(2'd0, 2'd0, 2'd1);
      wait_idle();

      // R4: read of block owned by another cache
      exp_inv(1'b1, 2'd0, 2'd1, "R4 downgrade to owner");
      exp_rsp(2'd0, 2'd1, 2'd1, 16'h1234, "R4 shared data after revision");
      send_req(2'd0, 2'd1, 2'd1);
      wait_inv_empty();
      send_ack(2'd1, 1'b1, 16'h1234);
      wait_idle();

      // R3: read of shared block
      exp_rsp(2'd0, 2'd2, 2'd1, 16'h1234, "R3 read shared block");
      send_req(2'd0, 2'd2, 2'd1);
      wait_idle();

      // R5 / R11: read-for-ownership with three sharers
      exp_inv(1'b0, 2'd0, 2'd1, "R11 R5 inval cache0 first");
      exp_inv(1'b0, 2'd1, 2'd1, "R11 R5 inval cache1 second");
      exp_inv(1'b0, 2'd2, 2'd1, "R11 R5 inval cache2 third");
      send_req(2'd1, 2'd3, 2'd1);
      wait_inv_empty();
      send_ack(2'd1, 1'b0, 16'h0);
      send_ack(2'd1, 1'b0, 16'h0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #2;
         chk(rsp_valid == 0, "R9 no completion before last reply", rsp_valid, 0);
      end
      // R8: refused while busy
      exp_rsp(2'd3, 2'd0, 2'd1, 16'h0, "R8 refusal to busy entry");
      send_req(2'd0, 2'd0, 2'd1);
      wait_idle();
      exp_rsp(2'd1, 2'd3, 2'd1, 16'h1234, "R5 exclusive data after all replies");
      send_ack(2'd1, 1'b0, 16'h0);
      wait_idle();

      // R8: state unchanged by refusal, cache3 still sole owner
      exp_inv(1'b1, 2'd3, 2'd1, "R8 owner unchanged after refusal");
      exp_rsp(2'd0, 2'd1, 2'd1, 16'h1234, "R8 shared data after downgrade");
      send_req(2'd0, 2'd1, 2'd1);
      wait_inv_empty();
      send_ack(2'd1, 1'b0, 16'h0);
      wait_idle();

      // R6: read-for-ownership of owned block, dirty revision
      exp_inv(1'b0, 2'd0, 2'd0, "R6 inval former owner");
      exp_rsp(2'd1, 2'd2, 2'd0, 16'h5555, "R6 revised data to new owner");
      send_req(2'd1, 2'd2, 2'd0);
      wait_inv_empty();
      send_ack(2'd0, 1'b1, 16'h5555);
      wait_idle();

      // R7: upgrade
      exp_rsp(2'd1, 2'd0, 2'd2, 16'hD002, "R7 setup read blk2");
      send_req(2'd0, 2'd0, 2'd2);
      wait_idle();
      exp_inv(1'b1, 2'd0, 2'd2, "R7 setup downgrade");
      exp_rsp(2'd0, 2'd1, 2'd2, 16'hD002, "R7 setup shared");
      send_req(2'd0, 2'd1, 2'd2);
      wait_inv_empty();
      send_ack(2'd2, 1'b0, 16'h0);
      wait_idle();
      exp_inv(1'b0, 2'd0, 2'd2, "R7 upgrade invalidates other sharer");
      exp_rsp(2'd2, 2'd1, 2'd2, 16'h0, "R7 grant without data");
      send_req(2'd2, 2'd1, 2'd2);
      wait_inv_empty();
      send_ack(2'd2, 1'b0, 16'h0);
      wait_idle();
      exp_rsp(2'd2, 2'd1, 2'd2, 16'h0, "R7 immediate grant sole sharer");
      send_req(2'd2, 2'd1, 2'd2);
      wait_idle();

      // R10: back-to-back requests to different idle entries
      begin
         int t1;
         exp_rsp(2'd1, 2'd0, 2'd3, 16'hD003, "R10 first request");
         exp_rsp(2'd1, 2'd2, 2'd0, 16'h5555, "R10 second request owner reread");
         send_req(2'd0, 2'd0, 2'd3);
         t1 = acc_cyc;
         send_req(2'd0, 2'd2, 2'd0);
         chk(acc_cyc == t1 + 1, "R10 consecutive acceptance", acc_cyc - t1, 1);
      end
      wait_idle();
      chk(rsp_q.size() == 0 && inv_q.size() == 0, "R9 all expected messages seen",
          rsp_q.size() + inv_q.size(), 0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule